// File: doc/BRIEF.md
# NAND Page Column Pointer Controller

This unit sits on the device side of a NAND page interface. It follows the byte pointer and the page address while a host reads a page out of the page register, or fills the register with data for a program operation. One page holds 528 bytes in three areas. The lower main half covers columns 0 to 255. The upper main half covers columns 256 to 511. The spare area covers columns 512 to 527. The command decoder ahead of this unit sends it one-cycle strobes. The bus logic sends it one strobe for each address byte, for each output byte and for each input byte.

There are three pointer modes, and each lasts for a different time. The lower-half mode is the default. The upper-half mode covers only the next address sequence, and the pointer then falls back to the lower half. The spare-area mode uses only the low four bits of the column byte and stays in force until the lower-half command or a reset arrives. During a read, when the pointer moves past the last column, the unit moves to the next page. It asks the array for a load and is busy until that load completes. The pointer then starts again at column 0, or at column 512 in spare mode. After the last page of the device, it stops and raises an end-of-device flag.

Top module: `nand_colptr`

## Requirements
- R1: After `rst` or a `cmd_reset` strobe, `column` is 0, `busy`, `load_req`, `end_of_page` and `end_of_dev` are low, and the pointer mode is the lower main half with no pending one-shot. A `cmd_reset` also sets `page_addr` to 0.
- R2: In lower-half mode, the first address byte after a read or program command sets `column` to that byte's value.
- R3: `cmd_half_hi` makes the next first address byte set `column` to 256 plus the byte. After that address sequence the mode is the lower half again, so a later address sequence with no new mode command starts at the byte's value.
- R4: `cmd_spare` makes the first address byte set `column` to 512 plus bits 3:0 of the byte. Bits 7:4 are ignored. The mode stays in force over any number of operations until `cmd_half_lo` or a reset.
- R5: An address sequence has four address cycles: the column byte, then the row bits 7:0, 15:8 and 16 (the low bit of the fourth byte). On the fourth cycle after a read command, `page_addr` takes the row, `load_req` pulses for one cycle, and `busy` stays high until `load_done`.
- R6: In read-out, each `rd_stb` moves `column` up by one. An `rd_stb` while `busy` is high, or when no read-out is in progress, leaves `column` unchanged.
- R7: An `rd_stb` at column 527 pulses `end_of_page`, moves `page_addr` up by one, sets `column` to 0 (lower or upper half mode) or to 512 (spare mode), pulses `load_req` and raises `busy`.
- R8: The page increment carries from the page-in-block field (`page_addr` bits 4:0) into the block field (bits 16:5).
- R9: An `rd_stb` at column 527 of page 0x1FFFF pulses `end_of_page` and sets `end_of_dev`. It starts no load, leaves `busy` low and leaves `page_addr` unchanged. `end_of_dev` clears at the next completed address sequence.
- R10: After `cmd_prog`, the start column follows the pointer mode exactly as it does for a read. Each `wr_stb` moves `column` up by one. A `wr_stb` at 527 pulses `end_of_page` and leaves `column` at 527 with no page load. After `cmd_prog_go`, data strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_half_lo | input | 1 | Read command strobe, lower main half |
| cmd_half_hi | input | 1 | Read command strobe, upper main half (one-shot) |
| cmd_spare | input | 1 | Read command strobe, spare area (sticky) |
| cmd_prog | input | 1 | Serial data input command strobe |
| cmd_prog_go | input | 1 | Program confirm strobe; ends data input |
| cmd_reset | input | 1 | Reset command strobe |
| addr_we | input | 1 | Address byte strobe |
| addr_byte | input | 8 | Address byte value |
| rd_stb | input | 1 | One output byte taken |
| wr_stb | input | 1 | One input byte written |
| load_done | input | 1 | Array-to-register transfer finished |
| column | output | 10 | Current column pointer |
| page_addr | output | 17 | Current page address {block, page-in-block} |
| load_req | output | 1 | One-cycle request to load a page |
| busy | output | 1 | Waiting for a page load |
| end_of_page | output | 1 | One-cycle pulse when the last column is consumed |
| end_of_dev | output | 1 | Sequential read ran past the last page |

## Verification
Reads are started in each of the three modes, with column bytes whose upper bits are set. This separates a correct spare offset from a full-byte offset, and a one-shot upper-half mode from a sticky one. Sequential reads are run across the page boundary in the upper-half mode and in the spare mode, which shows whether the restart column follows the persistent mode. They also start on the last page of a block, which exposes a missing carry into the block field, and on the last page of the device, which must stop with no load. Program data input runs to the last column, then strobes arrive after the confirm and during busy. This shows that the pointer saturates in fill mode and that strobes arriving outside read-out or data input leave it unchanged.

// File: rtl/nand_colptr_pkg.sv
package nand_colptr_pkg;

    typedef enum logic [1:0] {
        AREA_MAIN_LO = 2'd0,
        AREA_MAIN_HI = 2'd1,
        AREA_SPARE   = 2'd2
    } area_e;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_ADDR_RD = 3'd1,
        PH_ADDR_WR = 3'd2,
        PH_LOAD    = 3'd3,
        PH_STREAM  = 3'd4,
        PH_FILL    = 3'd5
    } phase_e;

    typedef struct packed {
        logic half_lo;
        logic half_hi;
        logic spare;
        logic prog;
        logic prog_go;
        logic reset;
    } cmd_t;

    // First column of an operation, from the area and the column byte.
    function automatic logic [15:0] start_col(area_e a, logic [7:0] b,
                                              int unsigned half,
                                              int unsigned spare_mask);
        logic [15:0] bw;
        bw = {8'h00, b};
        case (a)
            AREA_MAIN_LO: return bw & 16'(half - 1);
            AREA_MAIN_HI: return 16'(half) + (bw & 16'(half - 1));
            AREA_SPARE:   return 16'(2 * half) + (bw & 16'(spare_mask));
            default:      return 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/nand_colptr_mode.sv
module nand_colptr_mode
    import nand_colptr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  set_lo,
    input  logic  set_hi,
    input  logic  set_spare,
    input  logic  soft_rst,
    input  logic  consume,
    output area_e area_eff,
    output logic  spare_sticky
);
    logic spare_q;
    logic oneshot_q;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            spare_q   <= 1'b0;
            oneshot_q <= 1'b0;
        end else if (set_lo) begin
            spare_q   <= 1'b0;
            oneshot_q <= 1'b0;
        end else if (set_hi) begin
            spare_q   <= 1'b0;
            oneshot_q <= 1'b1;
        end else if (set_spare) begin
            spare_q   <= 1'b1;
            oneshot_q <= 1'b0;
        end else if (consume) begin
            oneshot_q <= 1'b0;
        end
    end

    always_comb begin
        if (oneshot_q)    area_eff = AREA_MAIN_HI;
        else if (spare_q) area_eff = AREA_SPARE;
        else              area_eff = AREA_MAIN_LO;
    end

    assign spare_sticky = spare_q;
endmodule

// File: rtl/nand_colptr_addr.sv
module nand_colptr_addr #(
    parameter int ROW_W    = 17,
    parameter int ADDR_CYC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             active,
    input  logic             addr_we,
    input  logic [7:0]       addr_byte,
    output logic             col_stb,
    output logic             row_stb,
    output logic [ROW_W-1:0] row_val
);
    localparam int CNT_W = $clog2(ADDR_CYC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [ROW_W-1:0] acc_q;
    logic [ROW_W-1:0] acc_nx;
    logic             take;

    assign take    = active && addr_we && (int'(cnt_q) < ADDR_CYC);
    assign col_stb = take && (cnt_q == '0);
    assign row_stb = take && (int'(cnt_q) == ADDR_CYC - 1);

    // Row bytes arrive least significant first; bits beyond ROW_W drop.
    always_comb begin
        acc_nx = acc_q;
        if (take && (cnt_q != '0)) begin
            for (int i = 0; i < 8; i++) begin
                if ((int'(cnt_q) - 1) * 8 + i < ROW_W)
                    acc_nx[(int'(cnt_q) - 1) * 8 + i] = addr_byte[i];
            end
        end
    end

    assign row_val = acc_nx;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (take) begin
            cnt_q <= cnt_q + 1'b1;
            acc_q <= acc_nx;
        end
    end
endmodule

// File: rtl/nand_colptr_seq.sv
module nand_colptr_seq
    import nand_colptr_pkg::*;
#(
    parameter int HALF_BYTES  = 256,
    parameter int SPARE_BYTES = 16,
    parameter int COL_W       = 10,
    parameter int PIB_W       = 5,
    parameter int BLK_W       = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  cmd_t                   cmd,
    input  area_e                  area_eff,
    input  logic                   spare_sticky,
    input  logic                   col_stb,
    input  logic                   row_stb,
    input  logic [PIB_W+BLK_W-1:0] row_val,
    input  logic [7:0]             addr_byte,
    input  logic                   rd_stb,
    input  logic                   wr_stb,
    input  logic                   load_done,
    output phase_e                 phase,
    output logic [COL_W-1:0]       column,
    output logic [PIB_W+BLK_W-1:0] page_addr,
    output logic                   load_req,
    output logic                   busy,
    output logic                   end_of_page,
    output logic                   end_of_dev
);
    localparam int ROW_W      = PIB_W + BLK_W;
    localparam int PAGE_BYTES = 2 * HALF_BYTES + SPARE_BYTES;
    localparam int LAST_COL   = PAGE_BYTES - 1;
    localparam int SPARE_BASE = 2 * HALF_BYTES;

    phase_e           ph_q;
    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] page_q;
    logic             req_q, eop_q, eod_q;

    logic [COL_W-1:0] col_start;
    logic [COL_W-1:0] col_restart;
    logic [PIB_W-1:0] pib_inc;
    logic [BLK_W-1:0] blk_inc;
    logic             pib_carry;
    logic             last_page;
    logic             at_last_col;

    assign col_start   = COL_W'(start_col(area_eff, addr_byte,
                                          HALF_BYTES, SPARE_BYTES - 1));
    assign col_restart = spare_sticky ? COL_W'(SPARE_BASE) : '0;
    assign at_last_col = (col_q == COL_W'(LAST_COL));

    // Page step: page-in-block field wraps and carries into the block field.
    assign pib_carry = &page_q[PIB_W-1:0];
    assign pib_inc   = page_q[PIB_W-1:0] + 1'b1;
    assign blk_inc   = page_q[ROW_W-1:PIB_W] + BLK_W'(pib_carry);
    assign last_page = &page_q;

    always_ff @(posedge clk) begin
        if (rst || cmd.reset) begin
            ph_q   <= PH_IDLE;
            col_q  <= '0;
            page_q <= '0;
            req_q  <= 1'b0;
            eop_q  <= 1'b0;
            eod_q  <= 1'b0;
        end else begin
            req_q <= 1'b0;
            eop_q <= 1'b0;
            if (cmd.half_lo || cmd.half_hi || cmd.spare) begin
                ph_q <= PH_ADDR_RD;
            end else if (cmd.prog) begin
                ph_q <= PH_ADDR_WR;
            end else if (cmd.prog_go) begin
                if (ph_q == PH_ADDR_WR || ph_q == PH_FILL) ph_q <= PH_IDLE;
            end else begin
                case (ph_q)
                    PH_ADDR_RD, PH_ADDR_WR: begin
                        if (col_stb) col_q <= col_start;
                        if (row_stb) begin
                            page_q <= row_val;
                            eod_q  <= 1'b0;
                            if (ph_q == PH_ADDR_RD) begin
                                ph_q  <= PH_LOAD;
                                req_q <= 1'b1;
                            end else begin
                                ph_q <= PH_FILL;
                            end
                        end
                    end
                    PH_LOAD: begin
                        if (load_done) ph_q <= PH_STREAM;
                    end
                    PH_STREAM: begin
                        if (rd_stb) begin
                            if (at_last_col) begin
                                eop_q <= 1'b1;
                                if (last_page) begin
                                    eod_q <= 1'b1;
                                    ph_q  <= PH_IDLE;
                                end else begin
                                    page_q <= {blk_inc, pib_inc};
                                    col_q  <= col_restart;
                                    req_q  <= 1'b1;
                                    ph_q   <= PH_LOAD;
                                end
                            end else begin
                                col_q <= col_q + 1'b1;
                            end
                        end
                    end
                    PH_FILL: begin
                        if (wr_stb) begin
                            if (at_last_col) eop_q <= 1'b1;
                            else             col_q <= col_q + 1'b1;
                        end
                    end
                    default: ph_q <= PH_IDLE;
                endcase
            end
        end
    end

    assign phase       = ph_q;
    assign column      = col_q;
    assign page_addr   = page_q;
    assign load_req    = req_q;
    assign busy        = (ph_q == PH_LOAD);
    assign end_of_page = eop_q;
    assign end_of_dev  = eod_q;
endmodule

// File: rtl/nand_colptr.sv
module nand_colptr
    import nand_colptr_pkg::*;
#(
    parameter int HALF_BYTES      = 256,
    parameter int SPARE_BYTES     = 16,
    parameter int PAGES_PER_BLOCK = 32,
    parameter int BLOCKS          = 4096,
    localparam int PAGE_BYTES     = 2 * HALF_BYTES + SPARE_BYTES,
    localparam int COL_W          = $clog2(PAGE_BYTES),
    localparam int PIB_W          = $clog2(PAGES_PER_BLOCK),
    localparam int BLK_W          = $clog2(BLOCKS),
    localparam int ROW_W          = PIB_W + BLK_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_half_lo,
    input  logic             cmd_half_hi,
    input  logic             cmd_spare,
    input  logic             cmd_prog,
    input  logic             cmd_prog_go,
    input  logic             cmd_reset,
    input  logic             addr_we,
    input  logic [7:0]       addr_byte,
    input  logic             rd_stb,
    input  logic             wr_stb,
    input  logic             load_done,
    output logic [COL_W-1:0] column,
    output logic [ROW_W-1:0] page_addr,
    output logic             load_req,
    output logic             busy,
    output logic             end_of_page,
    output logic             end_of_dev
);
    localparam int ADDR_CYC = 1 + (ROW_W + 7) / 8;

    cmd_t   cmd;
    area_e  area_eff;
    phase_e phase;
    logic   spare_sticky;
    logic   col_stb, row_stb;
    logic   addr_active;
    logic   addr_restart;
    logic [ROW_W-1:0] row_val;

    assign cmd = '{half_lo: cmd_half_lo, half_hi: cmd_half_hi,
                   spare:   cmd_spare,   prog:    cmd_prog,
                   prog_go: cmd_prog_go, reset:   cmd_reset};

    assign addr_restart = cmd_half_lo | cmd_half_hi | cmd_spare |
                          cmd_prog | cmd_reset;
    assign addr_active  = (phase == PH_ADDR_RD) || (phase == PH_ADDR_WR);

    nand_colptr_mode u_mode (
        .clk          (clk),
        .rst          (rst),
        .set_lo       (cmd_half_lo),
        .set_hi       (cmd_half_hi),
        .set_spare    (cmd_spare),
        .soft_rst     (cmd_reset),
        .consume      (col_stb),
        .area_eff     (area_eff),
        .spare_sticky (spare_sticky)
    );

    nand_colptr_addr #(
        .ROW_W    (ROW_W),
        .ADDR_CYC (ADDR_CYC)
    ) u_addr (
        .clk       (clk),
        .rst       (rst),
        .restart   (addr_restart),
        .active    (addr_active),
        .addr_we   (addr_we),
        .addr_byte (addr_byte),
        .col_stb   (col_stb),
        .row_stb   (row_stb),
        .row_val   (row_val)
    );

    nand_colptr_seq #(
        .HALF_BYTES  (HALF_BYTES),
        .SPARE_BYTES (SPARE_BYTES),
        .COL_W       (COL_W),
        .PIB_W       (PIB_W),
        .BLK_W       (BLK_W)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .cmd          (cmd),
        .area_eff     (area_eff),
        .spare_sticky (spare_sticky),
        .col_stb      (col_stb),
        .row_stb      (row_stb),
        .row_val      (row_val),
        .addr_byte    (addr_byte),
        .rd_stb       (rd_stb),
        .wr_stb       (wr_stb),
        .load_done    (load_done),
        .phase        (phase),
        .column       (column),
        .page_addr    (page_addr),
        .load_req     (load_req),
        .busy         (busy),
        .end_of_page  (end_of_page),
        .end_of_dev   (end_of_dev)
    );
endmodule

// File: rtl/nand_colptr_chk.sv
module nand_colptr_chk #(
    parameter int COL_W      = 10,
    parameter int ROW_W      = 17,
    parameter int PAGE_BYTES = 528,
    parameter int SPARE_BASE = 512
) (
    input logic             clk,
    input logic             rst,
    input logic             any_cmd,
    input logic             cmd_reset,
    input logic             load_done,
    input logic [COL_W-1:0] column,
    input logic [ROW_W-1:0] page_addr,
    input logic             load_req,
    input logic             busy,
    input logic             end_of_page,
    input logic             end_of_dev
);
    AST_COL_IN_PAGE: assert property (@(posedge clk) disable iff (rst)
        int'(column) < PAGE_BYTES);                                     // R6

    AST_BUSY_HOLDS_COL: assert property (@(posedge clk) disable iff (rst)
        (busy && !load_done && !any_cmd) |=> $stable(column));          // R6

    AST_LOAD_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        load_req |-> busy);                                             // R5

    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (rst)
        cmd_reset |=> (column == '0 && !busy && !end_of_dev));          // R1

    AST_WRAP_START: assert property (@(posedge clk) disable iff (rst)
        (end_of_page && load_req) |->
            (column == '0 || column == COL_W'(SPARE_BASE)));            // R7

    AST_WRAP_PAGE_STEP: assert property (@(posedge clk) disable iff (rst)
        (end_of_page && load_req) |->
            (page_addr == ROW_W'($past(page_addr) + 1'b1)));            // R8

    AST_EOD_LAST_PAGE: assert property (@(posedge clk) disable iff (rst)
        end_of_dev |-> (&page_addr));                                   // R9

    AST_EOD_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (end_of_dev && end_of_page) |-> (!load_req && !busy));          // R9
endmodule

bind nand_colptr nand_colptr_chk #(
    .COL_W      (COL_W),
    .ROW_W      (ROW_W),
    .PAGE_BYTES (PAGE_BYTES),
    .SPARE_BASE (2 * HALF_BYTES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .any_cmd     (cmd_half_lo | cmd_half_hi | cmd_spare | cmd_prog |
                  cmd_prog_go | cmd_reset),
    .cmd_reset   (cmd_reset),
    .load_done   (load_done),
    .column      (column),
    .page_addr   (page_addr),
    .load_req    (load_req),
    .busy        (busy),
    .end_of_page (end_of_page),
    .end_of_dev  (end_of_dev)
);

// File: tb/nand_colptr_tb.sv
module nand_colptr_tb;
    localparam int CLK_PERIOD = 10;

    localparam logic [5:0] C_LO    = 6'b000001;
    localparam logic [5:0] C_HI    = 6'b000010;
    localparam logic [5:0] C_SPARE = 6'b000100;
    localparam logic [5:0] C_PROG  = 6'b001000;
    localparam logic [5:0] C_GO    = 6'b010000;
    localparam logic [5:0] C_RST   = 6'b100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_half_lo = 0, cmd_half_hi = 0, cmd_spare = 0;
    logic        cmd_prog = 0, cmd_prog_go = 0, cmd_reset = 0;
    logic        addr_we = 0;
    logic [7:0]  addr_byte = 8'h00;
    logic        rd_stb = 0, wr_stb = 0, load_done = 0;
    logic [9:0]  column;
    logic [16:0] page_addr;
    logic        load_req, busy, end_of_page, end_of_dev;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nand_colptr u_dut (
        .clk(clk), .rst(rst),
        .cmd_half_lo(cmd_half_lo), .cmd_half_hi(cmd_half_hi),
        .cmd_spare(cmd_spare), .cmd_prog(cmd_prog),
        .cmd_prog_go(cmd_prog_go), .cmd_reset(cmd_reset),
        .addr_we(addr_we), .addr_byte(addr_byte),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .load_done(load_done),
        .column(column), .page_addr(page_addr), .load_req(load_req),
        .busy(busy), .end_of_page(end_of_page), .end_of_dev(end_of_dev)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic issue(logic [5:0] c);
        {cmd_reset, cmd_prog_go, cmd_prog, cmd_spare, cmd_half_hi, cmd_half_lo} = c;
        tick();
        {cmd_reset, cmd_prog_go, cmd_prog, cmd_spare, cmd_half_hi, cmd_half_lo} = '0;
    endtask

    task automatic send_addr(logic [7:0] col, int row);
        logic [31:0] r;
        r = row;
        addr_we = 1'b1;
        addr_byte = col;          tick();
        addr_byte = r[7:0];       tick();
        addr_byte = r[15:8];      tick();
        addr_byte = r[23:16];     tick();
        addr_we = 1'b0;
    endtask

    task automatic finish_load();
        load_done = 1'b1; tick(); load_done = 1'b0;
    endtask

    task automatic read_n(int n);
        for (int i = 0; i < n; i++) begin
            rd_stb = 1'b1; tick();
        end
        rd_stb = 1'b0;
    endtask

    task automatic write_n(int n);
        for (int i = 0; i < n; i++) begin
            wr_stb = 1'b1; tick();
        end
        wr_stb = 1'b0;
    endtask

    task automatic t_reset_state();
        check("R1", "column", column, 0);
        check("R1", "busy", busy, 0);
        check("R1", "load_req", load_req, 0);
        check("R1", "eop", end_of_page, 0);
        check("R1", "eod", end_of_dev, 0);
    endtask

    task automatic t_read_lo();
        issue(C_LO);
        send_addr(8'h10, 5);
        check("R2", "column", column, 16);
        check("R5", "page", page_addr, 5);
        check("R5", "load_req", load_req, 1);
        check("R5", "busy", busy, 1);
        read_n(2);
        check("R6", "column while busy", column, 16);
        check("R5", "load_req one cycle", load_req, 0);
        finish_load();
        check("R5", "busy after done", busy, 0);
        read_n(3);
        check("R6", "column after 3", column, 19);
    endtask

    task automatic t_read_hi_wrap();
        issue(C_HI);
        send_addr(8'h20, 10);
        check("R3", "column", column, 288);
        finish_load();
        read_n(239);
        check("R6", "column at end", column, 527);
        read_n(1);
        check("R7", "eop", end_of_page, 1);
        check("R7", "restart column", column, 0);
        check("R7", "page", page_addr, 11);
        check("R7", "load_req", load_req, 1);
        check("R7", "busy", busy, 1);
        tick();
        check("R7", "eop one cycle", end_of_page, 0);
        issue(C_PROG);
        send_addr(8'h87, 3);
        check("R3", "one-shot reverted", column, 135);
    endtask

    task automatic t_spare_modes();
        issue(C_SPARE);
        send_addr(8'hF3, 40);
        check("R4", "upper bits ignored", column, 515);
        finish_load();
        read_n(12);
        check("R6", "spare end", column, 527);
        read_n(1);
        check("R7", "spare restart", column, 512);
        check("R7", "page", page_addr, 41);
        issue(C_PROG);
        send_addr(8'h35, 2);
        check("R4", "sticky prog", column, 517);
        check("R10", "no load on prog", load_req, 0);
        issue(C_LO);
        send_addr(8'h35, 2);
        check("R4", "cleared by lo", column, 53);
        finish_load();
    endtask

    task automatic t_carry();
        issue(C_SPARE);
        send_addr(8'hFF, 191);
        check("R4", "col 527", column, 527);
        finish_load();
        read_n(1);
        check("R8", "carry page", page_addr, 192);
        check("R7", "spare restart", column, 512);
        finish_load();
    endtask

    task automatic t_end_dev();
        issue(C_SPARE);
        send_addr(8'h0F, 32'h1FFFF);
        check("R5", "last page", page_addr, 32'h1FFFF);
        finish_load();
        read_n(1);
        check("R9", "eop", end_of_page, 1);
        check("R9", "eod", end_of_dev, 1);
        check("R9", "no load", load_req, 0);
        check("R9", "not busy", busy, 0);
        check("R9", "page held", page_addr, 32'h1FFFF);
        read_n(2);
        check("R6", "idle strobe ignored", column, 527);
        check("R9", "eod stays", end_of_dev, 1);
        issue(C_LO);
        send_addr(8'h01, 7);
        check("R9", "eod cleared", end_of_dev, 0);
        finish_load();
    endtask

    task automatic t_program();
        issue(C_LO);
        issue(C_PROG);
        send_addr(8'hFE, 9);
        check("R10", "start", column, 254);
        write_n(3);
        check("R10", "advance", column, 257);
        issue(C_SPARE);
        issue(C_PROG);
        send_addr(8'h0E, 9);
        write_n(1);
        check("R10", "at 527", column, 527);
        write_n(1);
        check("R10", "eop", end_of_page, 1);
        check("R10", "saturate", column, 527);
        check("R10", "no load", load_req, 0);
        issue(C_GO);
        write_n(2);
        read_n(2);
        check("R10", "strobes after confirm", column, 527);
    endtask

    task automatic t_soft_reset();
        issue(C_SPARE);
        send_addr(8'h02, 4);
        issue(C_RST);
        check("R1", "column", column, 0);
        check("R1", "busy", busy, 0);
        check("R1", "page", page_addr, 0);
        issue(C_PROG);
        send_addr(8'h05, 1);
        check("R1", "mode back to lo", column, 5);
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset_state();
        t_read_lo();
        t_read_hi_wrap();
        t_spare_modes();
        t_carry();
        t_end_dev();
        t_program();
        t_soft_reset();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule